// File: doc/BRIEF.md
# Reservation Station Wakeup Scheduler

This block is the waiting pool that sits between register renaming and the execution ports of an out-of-order core. Each cycle it accepts a group of up to four renamed micro-ops. For each micro-op it stores the operation code, the destination physical tag and two source operands. A source that names an architectural register takes its value from the committed register file. A source that names a physical register already written takes its value from that reorder-buffer entry. Any other source is parked with its tag and waits for a result.

Execution units announce each result on a tagged broadcast bus. Every stored operand that is still waiting compares its tag against every broadcast lane in the same cycle and captures the matching value. Entries whose operands are all present compete for the execution ports that report themselves free. The oldest entries win, and each winner leaves the pool at that clock edge. A flush input empties the pool in one cycle.

The allocate side is a valid/ready stream. Slot k is accepted on a rising edge where `alloc_valid[k]` and `alloc_ready` are both high. `alloc_ready` never depends on `alloc_valid`. The dispatch side treats `fu_busy[p]` as the inverse of a ready signal. `disp_valid[p]` is only raised for a port whose `fu_busy[p]` is low, so every dispatch shown is complete in that cycle, and a busy port simply receives nothing.

Top module: `rs_wakeup_scheduler`

## Requirements
- R1: The pool holds ENTRIES (default 20) micro-ops. `alloc_ready` is high exactly when `flush` is low and at least ALLOC_W entries are free at the start of the cycle. On acceptance each slot with `alloc_valid` high occupies one free entry, and slots with `alloc_valid` low occupy nothing.
- R2: A source with `alloc_src_phys` = 0 (committed-register origin) is stored ready with its `alloc_src_commit_val`.
- R3: A source with `alloc_src_phys` = 1 and `alloc_src_done` = 1 is stored ready with its `alloc_src_rob_val`.
- R4: A source with `alloc_src_phys` = 1 and `alloc_src_done` = 0 is stored waiting on `alloc_src_tag`. It captures `bc_data` of the broadcast lane whose valid tag equals its own, and may dispatch from the next cycle on.
- R5: A waiting source whose tag matches a valid broadcast in its own allocation cycle is stored ready with that broadcast's data.
- R6: An entry is dispatched only when both of its sources are ready, and only to a port whose `fu_busy` bit is low. `disp_valid` is never high for a busy port.
- R7: Among dispatchable entries, the k-th oldest goes to the k-th non-busy port, counting ports from 0 upward, so at most PORTS leave per cycle. Age follows acceptance cycle, and within one cycle a lower slot number is older. The port carries the entry's op code, destination tag, and source values in `disp_src[p][0]` and `disp_src[p][1]`.
- R8: A dispatched entry leaves the pool at that clock edge and is never dispatched twice.
- R9: While `flush` is high, no dispatch is signalled and `alloc_ready` is low. At that edge every entry is emptied.
- R10: After reset the pool is empty, `alloc_ready` is high and no `disp_valid` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the pool at the next edge |
| alloc_valid | input | ALLOC_W | Per-slot allocate request |
| alloc_ready | output | 1 | Whole group can be accepted this cycle |
| alloc_op | input | ALLOC_W x OP_W | Operation code per slot |
| alloc_dst | input | ALLOC_W x TAG_W | Destination physical tag per slot |
| alloc_src_phys | input | ALLOC_W x SRCS | 1: source names a physical register |
| alloc_src_done | input | ALLOC_W x SRCS | Physical source already written |
| alloc_src_tag | input | ALLOC_W x SRCS x TAG_W | Physical tag of each source |
| alloc_src_commit_val | input | ALLOC_W x SRCS x DATA_W | Value read from the committed register file |
| alloc_src_rob_val | input | ALLOC_W x SRCS x DATA_W | Value read from the reorder-buffer entry |
| bc_valid | input | BCAST_W | Result broadcast lane valid |
| bc_tag | input | BCAST_W x TAG_W | Physical tag of the broadcast result |
| bc_data | input | BCAST_W x DATA_W | Broadcast result value |
| fu_busy | input | PORTS | Execution port cannot accept this cycle |
| disp_valid | output | PORTS | Micro-op issued on this port |
| disp_op | output | PORTS x OP_W | Issued operation code |
| disp_dst | output | PORTS x TAG_W | Issued destination tag |
| disp_src | output | PORTS x SRCS x DATA_W | Issued source values |

## Verification
The assertions take for granted that no two valid broadcast lanes carry the same tag in one cycle. They also take for granted that the producer of a tag broadcasts it while its consumers are waiting, since a lost wakeup would leave an entry parked forever. The random stimulus draws each cycle's broadcast tags as consecutive offsets from one random base, so lanes never collide. It keeps all tags in a small range, so that wakeups and allocation-cycle races happen often. Occasional flushes drain any entry whose tag was never broadcast. Directed phases then fill the pool to capacity behind busy ports, drain it through a sparse set of free ports, and flush it while an allocation is offered.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // number of source operands carried by every micro-op
  localparam int SRCS = 2;

  // origin of a source operand at allocation
  typedef enum logic {
    SRC_COMMITTED = 1'b0,
    SRC_PHYSICAL  = 1'b1
  } src_kind_e;
endpackage

// File: rtl/rs_src_capture.sv
// Operand capture cell: picks committed value, written physical value,
// or a same-cycle broadcast whose tag matches. Reused for wakeup of
// stored operands (physical, "done" = already ready).
module rs_src_capture
  import rs_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  parameter int BCAST_W = 4
) (
  input  logic                            is_phys,
  input  logic [TAG_W-1:0]                tag,
  input  logic                            done,
  input  logic [DATA_W-1:0]               arch_val,
  input  logic [DATA_W-1:0]               rob_val,
  input  logic [BCAST_W-1:0]              bc_valid,
  input  logic [BCAST_W-1:0][TAG_W-1:0]   bc_tag,
  input  logic [BCAST_W-1:0][DATA_W-1:0]  bc_data,
  output logic                            rdy,
  output logic [DATA_W-1:0]               val
);
  logic              hit;
  logic [DATA_W-1:0] hit_val;

  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int b = BCAST_W - 1; b >= 0; b--) begin
      if (bc_valid[b] && (bc_tag[b] == tag)) begin
        hit     = 1'b1;
        hit_val = bc_data[b];
      end
    end
  end

  always_comb begin
    if (src_kind_e'(is_phys) == SRC_COMMITTED) begin
      rdy = 1'b1;
      val = arch_val;
    end else if (done) begin
      rdy = 1'b1;
      val = rob_val;
    end else begin
      rdy = hit;
      val = hit ? hit_val : rob_val;
    end
  end
endmodule

// File: rtl/rs_alloc_pick.sv
// Maps allocate slot k onto the k-th lowest free entry.
module rs_alloc_pick #(
  parameter int ENTRIES = 20,
  parameter int ALLOC_W = 4
) (
  input  logic [ENTRIES-1:0]              free_mask,
  output logic [ALLOC_W-1:0][ENTRIES-1:0] slot_grant,
  output logic                            room
);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [CNT_W-1:0] seen;

  always_comb begin
    seen       = '0;
    slot_grant = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (free_mask[i]) begin
        for (int k = 0; k < ALLOC_W; k++) begin
          if (seen == CNT_W'(k)) slot_grant[k][i] = 1'b1;
        end
        seen = seen + 1'b1;
      end
    end
    room = (seen >= CNT_W'(ALLOC_W));
  end
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix plus rank-based selection: the k-th oldest eligible entry
// is sent to the k-th non-busy port.
module rs_age_pick #(
  parameter int ENTRIES = 20,
  parameter int PORTS   = 4,
  parameter int ALLOC_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              eligible,
  input  logic [PORTS-1:0]                fu_busy,
  input  logic [ALLOC_W-1:0][ENTRIES-1:0] new_grant,
  output logic [PORTS-1:0][ENTRIES-1:0]   port_grant
);
  localparam int RANK_W = $clog2(ENTRIES + 1);
  localparam int PR_W   = $clog2(PORTS + 1);
  localparam int SLOT_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;

  // older[j][i] = 1 : entry j was accepted before entry i
  logic [ENTRIES-1:0][ENTRIES-1:0] older;
  logic [ENTRIES-1:0]              is_new;
  logic [ENTRIES-1:0][SLOT_W-1:0]  new_slot;
  logic [ENTRIES-1:0][RANK_W-1:0]  rank;
  logic [PORTS-1:0][PR_W-1:0]      port_rank;
  logic [PR_W-1:0]                 free_cnt;
  logic [ENTRIES-1:0][PORTS-1:0]   entry_ports;

  always_comb begin
    is_new   = '0;
    new_slot = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (new_grant[k][i]) begin
          is_new[i]   = 1'b1;
          new_slot[i] = SLOT_W'(k);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (is_new[i] && is_new[j]) older[i][j] <= (new_slot[i] < new_slot[j]);
          else if (is_new[i])         older[i][j] <= 1'b0;
          else if (is_new[j])         older[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rank[i] = '0;
      for (int j = 0; j < ENTRIES; j++) begin
        if ((j != i) && eligible[j] && older[j][i]) rank[i] = rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    free_cnt = '0;
    for (int p = 0; p < PORTS; p++) begin
      port_rank[p] = free_cnt;
      if (!fu_busy[p]) free_cnt = free_cnt + 1'b1;
    end
  end

  always_comb begin
    for (int p = 0; p < PORTS; p++) begin
      for (int i = 0; i < ENTRIES; i++) begin
        port_grant[p][i] = eligible[i] && !fu_busy[p] &&
                           (rank[i] == RANK_W'(port_rank[p]));
        entry_ports[i][p] = port_grant[p][i];
      end
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
      // R7: one entry per port
      p_one_entry_per_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_grant[p]));
    end
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry_chk
      // R8: an entry is never issued on two ports at once
      p_one_port_per_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_ports[i]));
    end
  endgenerate
endmodule

// File: rtl/rs_wakeup_scheduler.sv
module rs_wakeup_scheduler
  import rs_pkg::*;
#(
  parameter int ENTRIES = 20,
  parameter int ALLOC_W = 4,
  parameter int PORTS   = 4,
  parameter int BCAST_W = 4,
  parameter int OP_W    = 6,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      flush,
  input  logic [ALLOC_W-1:0]                        alloc_valid,
  output logic                                      alloc_ready,
  input  logic [ALLOC_W-1:0][OP_W-1:0]              alloc_op,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]             alloc_dst,
  input  logic [ALLOC_W-1:0][SRCS-1:0]              alloc_src_phys,
  input  logic [ALLOC_W-1:0][SRCS-1:0]              alloc_src_done,
  input  logic [ALLOC_W-1:0][SRCS-1:0][TAG_W-1:0]   alloc_src_tag,
  input  logic [ALLOC_W-1:0][SRCS-1:0][DATA_W-1:0]  alloc_src_commit_val,
  input  logic [ALLOC_W-1:0][SRCS-1:0][DATA_W-1:0]  alloc_src_rob_val,
  input  logic [BCAST_W-1:0]                        bc_valid,
  input  logic [BCAST_W-1:0][TAG_W-1:0]             bc_tag,
  input  logic [BCAST_W-1:0][DATA_W-1:0]            bc_data,
  input  logic [PORTS-1:0]                          fu_busy,
  output logic [PORTS-1:0]                          disp_valid,
  output logic [PORTS-1:0][OP_W-1:0]                disp_op,
  output logic [PORTS-1:0][TAG_W-1:0]               disp_dst,
  output logic [PORTS-1:0][SRCS-1:0][DATA_W-1:0]    disp_src
);
  // entry storage
  logic [ENTRIES-1:0]                         ent_v;
  logic [ENTRIES-1:0][OP_W-1:0]               ent_op;
  logic [ENTRIES-1:0][TAG_W-1:0]              ent_dst;
  logic [ENTRIES-1:0][SRCS-1:0]               ent_rdy;
  logic [ENTRIES-1:0][SRCS-1:0][TAG_W-1:0]    ent_tag;
  logic [ENTRIES-1:0][SRCS-1:0][DATA_W-1:0]   ent_val;

  logic [ENTRIES-1:0][SRCS-1:0]               wake_rdy;
  logic [ENTRIES-1:0][SRCS-1:0][DATA_W-1:0]   wake_val;
  logic [ALLOC_W-1:0][SRCS-1:0]               new_rdy;
  logic [ALLOC_W-1:0][SRCS-1:0][DATA_W-1:0]   new_val;

  logic [ALLOC_W-1:0][ENTRIES-1:0] slot_grant;
  logic [ALLOC_W-1:0][ENTRIES-1:0] fire_grant;
  logic                            room;
  logic [ENTRIES-1:0]              eligible;
  logic [PORTS-1:0][ENTRIES-1:0]   port_grant;
  logic [ENTRIES-1:0]              disp_taken;

  // wakeup compare of every stored operand against every broadcast lane
  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      for (genvar s = 0; s < SRCS; s++) begin : g_src
        rs_src_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BCAST_W(BCAST_W)) u_wake (
          .is_phys (1'b1),
          .tag     (ent_tag[i][s]),
          .done    (ent_rdy[i][s]),
          .arch_val(DATA_W'(0)),
          .rob_val (ent_val[i][s]),
          .bc_valid(bc_valid),
          .bc_tag  (bc_tag),
          .bc_data (bc_data),
          .rdy     (wake_rdy[i][s]),
          .val     (wake_val[i][s])
        );
      end
    end
    // allocation-time capture, including same-cycle broadcast race
    for (genvar k = 0; k < ALLOC_W; k++) begin : g_slot
      for (genvar s = 0; s < SRCS; s++) begin : g_src
        rs_src_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BCAST_W(BCAST_W)) u_new (
          .is_phys (alloc_src_phys[k][s]),
          .tag     (alloc_src_tag[k][s]),
          .done    (alloc_src_done[k][s]),
          .arch_val(alloc_src_commit_val[k][s]),
          .rob_val (alloc_src_rob_val[k][s]),
          .bc_valid(bc_valid),
          .bc_tag  (bc_tag),
          .bc_data (bc_data),
          .rdy     (new_rdy[k][s]),
          .val     (new_val[k][s])
        );
      end
    end
  endgenerate

  rs_alloc_pick #(.ENTRIES(ENTRIES), .ALLOC_W(ALLOC_W)) u_alloc (
    .free_mask (~ent_v),
    .slot_grant(slot_grant),
    .room      (room)
  );

  assign alloc_ready = room && !flush;

  always_comb begin
    for (int k = 0; k < ALLOC_W; k++)
      fire_grant[k] = slot_grant[k] & {ENTRIES{alloc_valid[k] && alloc_ready}};
    for (int i = 0; i < ENTRIES; i++)
      eligible[i] = ent_v[i] && (&ent_rdy[i]);
  end

  rs_age_pick #(.ENTRIES(ENTRIES), .PORTS(PORTS), .ALLOC_W(ALLOC_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .eligible  (eligible),
    .fu_busy   (fu_busy),
    .new_grant (fire_grant),
    .port_grant(port_grant)
  );

  always_comb begin
    disp_taken = '0;
    for (int p = 0; p < PORTS; p++) begin
      disp_valid[p] = (|port_grant[p]) && !flush;
      disp_op[p]    = '0;
      disp_dst[p]   = '0;
      disp_src[p]   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (port_grant[p][i]) begin
          disp_op[p]    = disp_op[p]  | ent_op[i];
          disp_dst[p]   = disp_dst[p] | ent_dst[i];
          disp_src[p]   = disp_src[p] | ent_val[i];
          disp_taken[i] = !flush;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v   <= '0;
      ent_rdy <= '0;
    end else if (flush) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_rdy[i] <= wake_rdy[i];
        if (disp_taken[i]) ent_v[i] <= 1'b0;
        for (int k = 0; k < ALLOC_W; k++) begin
          if (fire_grant[k][i]) begin
            ent_v[i]   <= 1'b1;
            ent_rdy[i] <= new_rdy[k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      ent_val[i] <= wake_val[i];
      for (int k = 0; k < ALLOC_W; k++) begin
        if (fire_grant[k][i]) begin
          ent_op[i]  <= alloc_op[k];
          ent_dst[i] <= alloc_dst[k];
          ent_tag[i] <= alloc_src_tag[k];
          ent_val[i] <= new_val[k];
        end
      end
    end
  end

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
      // R6: nothing is issued to a busy port
      p_busy_port_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[p] |-> !fu_busy[p]);
    end
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent_chk
      // R6: only entries with all operands present are issued
      p_issue_needs_operands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_taken[i] |-> (ent_v[i] && (&ent_rdy[i])));
      // R8: an issued entry is gone after the edge
      p_issued_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_taken[i] |=> !ent_v[i]);
    end
  endgenerate

  // R9: flush empties the pool
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0));

  // R1: acceptance only with room for a whole group
  p_ready_has_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> ($countones(ent_v) <= ENTRIES - ALLOC_W));
endmodule

// File: tb/tb_rs_wakeup_scheduler.sv
module tb_rs_wakeup_scheduler;
  import rs_pkg::*;

  localparam int E = 20, AW = 4, P = 4, BW = 4, OPW = 6, TW = 6, DW = 16, S = SRCS;

  logic clk = 1'b0;
  logic rst_n, flush;
  logic [AW-1:0]                 alloc_valid;
  logic                          alloc_ready;
  logic [AW-1:0][OPW-1:0]        alloc_op;
  logic [AW-1:0][TW-1:0]         alloc_dst;
  logic [AW-1:0][S-1:0]          alloc_src_phys, alloc_src_done;
  logic [AW-1:0][S-1:0][TW-1:0]  alloc_src_tag;
  logic [AW-1:0][S-1:0][DW-1:0]  alloc_src_commit_val, alloc_src_rob_val;
  logic [BW-1:0]                 bc_valid;
  logic [BW-1:0][TW-1:0]         bc_tag;
  logic [BW-1:0][DW-1:0]         bc_data;
  logic [P-1:0]                  fu_busy, disp_valid;
  logic [P-1:0][OPW-1:0]         disp_op;
  logic [P-1:0][TW-1:0]          disp_dst;
  logic [P-1:0][S-1:0][DW-1:0]   disp_src;

  rs_wakeup_scheduler #(.ENTRIES(E), .ALLOC_W(AW), .PORTS(P), .BCAST_W(BW),
                        .OP_W(OPW), .TAG_W(TW), .DATA_W(DW)) dut (.*);

  always #4 clk = ~clk;

  // reference pool
  bit             m_v[E];
  logic [OPW-1:0] m_op[E];
  logic [TW-1:0]  m_dst[E];
  bit             m_rdy[E][S];
  logic [TW-1:0]  m_tag[E][S];
  logic [DW-1:0]  m_val[E][S];
  int             m_seq[E];
  int             seq_ctr = 0;
  int             checks = 0, fails = 0;
  string          cur_req = "R10";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = '0; bc_valid = '0; fu_busy = '0; flush = 1'b0;
    alloc_op = '0; alloc_dst = '0; alloc_src_phys = '0; alloc_src_done = '0;
    alloc_src_tag = '0; alloc_src_commit_val = '0; alloc_src_rob_val = '0;
    bc_tag = '0; bc_data = '0;
  endtask

  task automatic set_src(int k, int s, bit phys, bit done, int tag, logic [DW-1:0] v);
    alloc_src_phys[k][s] = phys;
    alloc_src_done[k][s] = done;
    alloc_src_tag[k][s]  = TW'(tag);
    alloc_src_commit_val[k][s] = phys ? ~v : v;
    alloc_src_rob_val[k][s]    = phys ? v : ~v;
  endtask

  // one cycle: compare against the reference, advance it, reach next negedge
  task automatic cycle();
    int  freec;
    bit  exp_rdy;
    int  pick[P];
    bit  taken[E];
    bit  pre_free[E];
    int  best;
    #1;
    freec = 0;
    for (int e = 0; e < E; e++) begin
      taken[e] = 0;
      pre_free[e] = !m_v[e];
      if (!m_v[e]) freec++;
    end
    exp_rdy = !flush && (freec >= AW);
    chk(cur_req, "alloc_ready", 32'(alloc_ready), 32'(exp_rdy));
    for (int p = 0; p < P; p++) begin
      pick[p] = -1;
      if (!flush && !fu_busy[p]) begin
        best = -1;
        for (int e = 0; e < E; e++)
          if (m_v[e] && !taken[e] && m_rdy[e][0] && m_rdy[e][1] &&
              (best < 0 || m_seq[e] < m_seq[best])) best = e;
        pick[p] = best;
        if (best >= 0) taken[best] = 1;
      end
      chk(cur_req, $sformatf("disp_valid[%0d]", p), 32'(disp_valid[p]), 32'(pick[p] >= 0));
      if (pick[p] >= 0) begin
        chk(cur_req, $sformatf("disp_op[%0d]", p), 32'(disp_op[p]), 32'(m_op[pick[p]]));
        chk(cur_req, $sformatf("disp_dst[%0d]", p), 32'(disp_dst[p]), 32'(m_dst[pick[p]]));
        chk(cur_req, $sformatf("disp_src[%0d][0]", p), 32'(disp_src[p][0]), 32'(m_val[pick[p]][0]));
        chk(cur_req, $sformatf("disp_src[%0d][1]", p), 32'(disp_src[p][1]), 32'(m_val[pick[p]][1]));
      end
    end
    if (flush) begin
      for (int e = 0; e < E; e++) m_v[e] = 0;
    end else begin
      for (int e = 0; e < E; e++)
        if (m_v[e])
          for (int s = 0; s < S; s++)
            if (!m_rdy[e][s])
              for (int b = 0; b < BW; b++)
                if (bc_valid[b] && bc_tag[b] == m_tag[e][s]) begin
                  m_rdy[e][s] = 1; m_val[e][s] = bc_data[b];
                end
      for (int e = 0; e < E; e++) if (taken[e]) m_v[e] = 0;
      if (exp_rdy) begin
        for (int k = 0; k < AW; k++) begin
          if (alloc_valid[k]) begin
            best = -1;
            for (int e = 0; e < E; e++) if (pre_free[e] && best < 0) best = e;
            pre_free[best] = 0;
            m_v[best] = 1; m_op[best] = alloc_op[k]; m_dst[best] = alloc_dst[k];
            m_seq[best] = seq_ctr++;
            for (int s = 0; s < S; s++) begin
              m_tag[best][s] = alloc_src_tag[k][s];
              m_rdy[best][s] = 0;
              if (!alloc_src_phys[k][s]) begin
                m_rdy[best][s] = 1; m_val[best][s] = alloc_src_commit_val[k][s];
              end else if (alloc_src_done[k][s]) begin
                m_rdy[best][s] = 1; m_val[best][s] = alloc_src_rob_val[k][s];
              end else begin
                for (int b = 0; b < BW; b++)
                  if (bc_valid[b] && bc_tag[b] == alloc_src_tag[k][s]) begin
                    m_rdy[best][s] = 1; m_val[best][s] = bc_data[b];
                  end
              end
            end
          end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic rand_in();
    int base;
    alloc_valid = AW'($urandom);
    for (int k = 0; k < AW; k++) begin
      alloc_op[k]  = OPW'($urandom);
      alloc_dst[k] = TW'($urandom);
      for (int s = 0; s < S; s++)
        set_src(k, s, ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 16, DW'($urandom));
    end
    base = $urandom % 16;
    for (int b = 0; b < BW; b++) begin
      bc_valid[b] = $urandom % 2;
      bc_tag[b]   = TW'((base + b) % 16);
      bc_data[b]  = DW'($urandom);
    end
    fu_busy = P'($urandom);
    flush   = ($urandom % 60) == 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int e = 0; e < E; e++) m_v[e] = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10", "alloc_ready after reset", 32'(alloc_ready), 32'd1);
    chk("R10", "disp_valid after reset", 32'(disp_valid), 32'd0);
    cur_req = "R10";
    cycle();

    // committed and already-written sources
    cur_req = "R2 R3";
    alloc_valid = 4'b0001; alloc_op[0] = 6'h11; alloc_dst[0] = 6'd9;
    set_src(0, 0, 0, 0, 3, 16'h1111);
    set_src(0, 1, 1, 1, 4, 16'h2222);
    cycle();
    idle(); cycle();

    // waiting source woken by a later broadcast
    cur_req = "R4";
    alloc_valid = 4'b0001; alloc_op[0] = 6'h22; alloc_dst[0] = 6'd10;
    set_src(0, 0, 1, 0, 5, 16'h0);
    set_src(0, 1, 0, 0, 0, 16'h3333);
    cycle();
    idle(); cycle(); cycle();
    bc_valid[0] = 1'b1; bc_tag[0] = 6'd5; bc_data[0] = 16'hBEEF;
    cycle();
    idle(); cycle();

    // broadcast in the allocation cycle
    cur_req = "R5";
    alloc_valid = 4'b0001; alloc_op[0] = 6'h33; alloc_dst[0] = 6'd11;
    set_src(0, 0, 1, 0, 7, 16'h0);
    set_src(0, 1, 1, 1, 8, 16'h4444);
    bc_valid[2] = 1'b1; bc_tag[2] = 6'd7; bc_data[2] = 16'h5A5A;
    cycle();
    idle(); cycle();

    // fill to capacity behind busy ports
    cur_req = "R1";
    for (int c = 0; c < 6; c++) begin
      idle(); fu_busy = '1; alloc_valid = '1;
      for (int k = 0; k < AW; k++) begin
        alloc_op[k] = OPW'(c * 4 + k); alloc_dst[k] = TW'(c * 4 + k + 20);
        set_src(k, 0, 0, 0, 0, DW'($urandom));
        set_src(k, 1, 1, 1, 1, DW'($urandom));
      end
      cycle();
    end
    cur_req = "R6";
    idle(); fu_busy = '1; cycle();
    cur_req = "R7";
    for (int c = 0; c < 5; c++) begin idle(); fu_busy = 4'b1010; cycle(); end
    cur_req = "R8";
    for (int c = 0; c < 6; c++) begin idle(); fu_busy = 4'b0110; cycle(); end

    // flush with an allocation offered
    cur_req = "R9";
    for (int c = 0; c < 2; c++) begin
      idle(); fu_busy = '1; alloc_valid = '1;
      for (int k = 0; k < AW; k++) begin
        set_src(k, 0, 0, 0, 0, DW'($urandom));
        set_src(k, 1, 1, 0, 12, 16'h0);
      end
      cycle();
    end
    idle(); flush = 1'b1; alloc_valid = '1;
    cycle();
    idle(); cycle();
    chk("R9", "disp_valid after flush", 32'(disp_valid), 32'd0);

    // random traffic
    cur_req = "R7";
    for (int c = 0; c < 4000; c++) begin
      rand_in();
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule